// File: doc/BRIEF.md
# Parallel NOR Flash Command and Mode Controller

This block sits behind the host-side bus of a parallel NOR flash macro. It interprets bytes written on a strobed write port as commands, tracks which view a read returns (cell contents, identifier codes, or the status register), and starts program and block-erase operations on a modelled internal engine. The engine is a busy counter with one fixed latency for programs and another for erases. The controller also owns the status register. A small cell model stands in for the storage so that the effect of each operation can be seen through ordinary reads.

A host writes one-byte commands on `wdata[7:0]` with a single-cycle `wr_en` pulse. Multi-step operations take two writes: a setup byte, then a second write that carries the target address and the data or confirmation. `rd_en` samples the current view, and `rdata` holds the result from the cycle after the strobe. While the engine is busy the controller accepts only the erase-suspend byte. Every other write is dropped, and reads always return the status byte.

The cell model is addressed by block bits `addr[12 +: BLK_BITS]` and word bits `addr[0 +: WORD_BITS]`. The full block field is `addr[19:12]`, and `BOOT_BLK` is the protected block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array view, `busy` is 0 and `rdata` is 0. Writing FFh returns to array view from any view. `rdata` updates on the clock edge that samples `rd_en`.
- R2: Array view persists across any number of reads. A write of a byte that is not a command (for example 00h or 34h) changes neither the view nor the cells.
- R3: After 90h, reads return 00A7h when `addr[0]`=0 and 00C3h when `addr[0]`=1, until the next command.
- R4: After 70h, reads return {8'h00, SR}. SR bit 7 is ready, bit 6 is erase suspended, bit 5 is erase sequence error, bit 1 is boot lock error, and all other bits are 0. Writing 50h clears bits 5 and 1 and leaves the view unchanged.
- R5: Writing 40h or 10h and then a data write programs the addressed cell to old AND data. In byte mode (`word_sel`=0) the data is {FFh, wdata[7:0]}, and array reads return {00h, low byte}. `busy` is high for exactly PROG_LAT cycles.
- R6: Writing 20h and then D0h erases every word of the block given by the address to FFFFh, with `busy` high for exactly ERASE_LAT cycles. Any second byte other than D0h starts nothing, sets SR bit 5 and selects status view.
- R7: B0h written during a busy erase drops `busy` on the next cycle, sets SR bits 7 and 6 and selects status view. While suspended, cells read their pre-erase values and 40h, 10h and 20h are ignored. D0h resumes the erase, and the busy cycles before and after the suspension add up to ERASE_LAT.
- R8: While `busy` is high, SR bit 7 reads 0, every write except the erase-suspend byte is ignored, and every read returns {8'h00, SR}.
- R9: When an operation ends, SR bit 7 becomes 1 and the controller stays in status view until another command is written.
- R10: After a program setup, a data write of all ones cancels the program. All ones is FFh in byte mode and FFFFh in word mode. No busy period follows, the cells are unchanged and the view becomes array. In word mode, 00FFh is a real program.
- R11: A program or erase aimed at block field `BOOT_BLK` (0) while `boot_unlock` is 0 starts nothing, sets SR bit 1 and selects status view. With `boot_unlock`=1 the operation proceeds normally.
- R12: A reset while an operation is active or suspended leaves corrupted data: a program target reads 0000h, and every word of an erase block reads 0000h. The controller then returns to array view with `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W (20) | Bus address |
| wdata | input | 16 | Write data; the command byte is in bits 7:0 |
| word_sel | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| boot_unlock | input | 1 | Permits program and erase of the boot block |
| rdata | output | 16 | Read data, registered |
| busy | output | 1 | Internal engine is running (not suspended) |

## Verification
The risky collisions are a B0h write that arrives on the last busy cycle of an erase, and a reset that arrives while an operation is still active. The first case is provoked by counting busy cycles before suspending, then checking that the busy cycles before and after the suspension add up to the erase latency. The second case is provoked by pulsing reset part-way through a program and through a suspended erase. The outcome is judged through array reads that must show the corruption pattern rather than either the old or the intended contents. Random programs, reads and erases in both data widths are compared against a bench-side cell model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PROG, SQ_ERASE} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [3:0] {
    CMD_NONE, CMD_ARRAY, CMD_IDENT, CMD_STATUS, CMD_CLEAR,
    CMD_PROG, CMD_ERASE, CMD_CONFIRM, CMD_SUSPEND
  } cmd_e;

  localparam logic [7:0] K_ARRAY   = 8'hFF;
  localparam logic [7:0] K_IDENT   = 8'h90;
  localparam logic [7:0] K_STATUS  = 8'h70;
  localparam logic [7:0] K_CLEAR   = 8'h50;
  localparam logic [7:0] K_PROG_A  = 8'h40;
  localparam logic [7:0] K_PROG_B  = 8'h10;
  localparam logic [7:0] K_ERASE   = 8'h20;
  localparam logic [7:0] K_CONFIRM = 8'hD0;
  localparam logic [7:0] K_SUSPEND = 8'hB0;

  // a null program: all ones in the active data width
  function automatic logic f_all_ones(input logic [15:0] d, input logic word);
    return word ? (d == 16'hFFFF) : (d[7:0] == 8'hFF);
  endfunction

  // programming can only clear bits
  function automatic logic [15:0] f_prog_merge(input logic [15:0] old,
                                               input logic [15:0] d,
                                               input logic word);
    return old & (word ? d : {8'hFF, d[7:0]});
  endfunction

  function automatic logic [15:0] f_width_view(input logic [15:0] v, input logic word);
    return word ? v : {8'h00, v[7:0]};
  endfunction

  function automatic logic [7:0] f_status(input logic ready, input logic susp,
                                          input logic seq_err, input logic lock_err);
    return {ready, susp, seq_err, 3'b000, lock_err, 1'b0};
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       kind
);
  always_comb begin
    case (code)
      K_ARRAY:            kind = CMD_ARRAY;
      K_IDENT:            kind = CMD_IDENT;
      K_STATUS:           kind = CMD_STATUS;
      K_CLEAR:            kind = CMD_CLEAR;
      K_PROG_A, K_PROG_B: kind = CMD_PROG;
      K_ERASE:            kind = CMD_ERASE;
      K_CONFIRM:          kind = CMD_CONFIRM;
      K_SUSPEND:          kind = CMD_SUSPEND;
      default:            kind = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          hold,
  output logic          running,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign running = run_q;
  assign done    = run_q && !hold && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= load;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q && !hold) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int BLK_BITS  = 2,
  parameter int WORD_BITS = 2
) (
  input  logic                 clk,
  input  logic                 apply_en,
  input  logic                 corrupt_en,
  input  op_e                  op_kind,
  input  logic [BLK_BITS-1:0]  op_blk,
  input  logic [WORD_BITS-1:0] op_word,
  input  logic [15:0]          op_data,
  input  logic                 op_wide,
  input  logic [BLK_BITS-1:0]  rd_blk,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic [15:0]          rd_val
);
  localparam int IW     = BLK_BITS + WORD_BITS;
  localparam int NCELLS = 1 << IW;
  localparam int NWORDS = 1 << WORD_BITS;

  logic [15:0] mem [NCELLS];
  logic [IW-1:0] op_idx;

  assign op_idx = {op_blk, op_word};
  assign rd_val = mem[{rd_blk, rd_word}];

  always_ff @(posedge clk) begin
    if (corrupt_en || apply_en) begin
      if (op_kind == OP_PROG) begin
        mem[op_idx] <= corrupt_en ? 16'h0000
                                  : f_prog_merge(mem[op_idx], op_data, op_wide);
      end else if (op_kind == OP_ERASE) begin
        for (int w = 0; w < NWORDS; w++) begin
          mem[{op_blk, WORD_BITS'(w)}] <= corrupt_en ? 16'h0000 : 16'hFFFF;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 20,
  parameter int         BLK_LSB   = 12,
  parameter int         BLK_BITS  = 2,
  parameter int         WORD_BITS = 2,
  parameter int         PROG_LAT  = 8,
  parameter int         ERASE_LAT = 24,
  parameter int         BOOT_BLK  = 0,
  parameter logic [7:0] MFR_CODE  = 8'hA7,
  parameter logic [7:0] DEV_CODE  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              word_sel,
  input  logic              boot_unlock,
  output logic [15:0]       rdata,
  output logic              busy
);
  localparam int BLK_FW = ADDR_W - BLK_LSB;
  localparam int MAXLAT = (ERASE_LAT > PROG_LAT) ? ERASE_LAT : PROG_LAT;
  localparam int CW     = $clog2(MAXLAT) + 1;

  rmode_e mode_q;
  seq_e   seq_q;
  op_e    op_q;
  logic   susp_q, seq_err_q, lock_err_q;
  logic [BLK_BITS-1:0]  op_blk_q;
  logic [WORD_BITS-1:0] op_word_q;
  logic [15:0]          op_data_q;
  logic                 op_wide_q;

  cmd_e        cmd;
  logic        tmr_run, op_done;
  logic [7:0]  status_byte;
  logic [15:0] cell_val;

  // named events
  logic wr_ok, locked, ones;
  logic ev_null, ev_prog_start, ev_erase_start, ev_seq_err, ev_lock_err;
  logic ev_suspend, ev_resume, ev_start;

  flash_cmd_decode u_dec (.code(wdata[7:0]), .kind(cmd));

  assign busy        = tmr_run && !susp_q;
  assign status_byte = f_status(!busy, susp_q, seq_err_q, lock_err_q);
  assign wr_ok       = wr_en && !busy;
  assign locked      = (addr[ADDR_W-1:BLK_LSB] == BLK_FW'(BOOT_BLK)) && !boot_unlock;
  assign ones        = f_all_ones(wdata, word_sel);

  assign ev_null        = wr_ok && (seq_q == SQ_PROG) && ones;
  assign ev_prog_start  = wr_ok && (seq_q == SQ_PROG) && !ones && !locked;
  assign ev_erase_start = wr_ok && (seq_q == SQ_ERASE) && (cmd == CMD_CONFIRM) && !locked;
  assign ev_seq_err     = wr_ok && (seq_q == SQ_ERASE) && (cmd != CMD_CONFIRM);
  assign ev_lock_err    = wr_ok && locked &&
                          (((seq_q == SQ_PROG) && !ones) ||
                           ((seq_q == SQ_ERASE) && (cmd == CMD_CONFIRM)));
  assign ev_suspend     = wr_en && busy && (cmd == CMD_SUSPEND) &&
                          (op_q == OP_ERASE) && !op_done;
  assign ev_resume      = wr_ok && (seq_q == SQ_IDLE) && (cmd == CMD_CONFIRM) && susp_q;
  assign ev_start       = ev_prog_start || ev_erase_start;

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ev_start),
    .load    (ev_prog_start ? CW'(PROG_LAT - 1) : CW'(ERASE_LAT - 1)),
    .hold    (susp_q),
    .running (tmr_run),
    .done    (op_done)
  );

  flash_cell_array #(.BLK_BITS(BLK_BITS), .WORD_BITS(WORD_BITS)) u_cells (
    .clk        (clk),
    .apply_en   (op_done),
    .corrupt_en (!rst_n && (op_q != OP_NONE)),
    .op_kind    (op_q),
    .op_blk     (op_blk_q),
    .op_word    (op_word_q),
    .op_data    (op_data_q),
    .op_wide    (op_wide_q),
    .rd_blk     (addr[BLK_LSB +: BLK_BITS]),
    .rd_word    (addr[0 +: WORD_BITS]),
    .rd_val     (cell_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= RM_ARRAY;
      seq_q      <= SQ_IDLE;
      op_q       <= OP_NONE;
      susp_q     <= 1'b0;
      seq_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
      op_blk_q   <= '0;
      op_word_q  <= '0;
      op_data_q  <= '0;
      op_wide_q  <= 1'b0;
    end else begin
      if (op_done) op_q <= OP_NONE;
      if (ev_suspend) begin
        susp_q <= 1'b1;
        mode_q <= RM_STATUS;
      end
      if (ev_start) begin
        op_q      <= ev_prog_start ? OP_PROG : OP_ERASE;
        op_blk_q  <= addr[BLK_LSB +: BLK_BITS];
        op_word_q <= addr[0 +: WORD_BITS];
        op_data_q <= wdata;
        op_wide_q <= word_sel;
      end
      if (ev_seq_err)  seq_err_q  <= 1'b1;
      if (ev_lock_err) lock_err_q <= 1'b1;
      if (wr_ok) begin
        if (seq_q != SQ_IDLE) begin
          seq_q  <= SQ_IDLE;
          mode_q <= ev_null ? RM_ARRAY : RM_STATUS;
        end else begin
          case (cmd)
            CMD_ARRAY:  mode_q <= RM_ARRAY;
            CMD_IDENT:  mode_q <= RM_IDENT;
            CMD_STATUS: mode_q <= RM_STATUS;
            CMD_CLEAR: begin
              seq_err_q  <= 1'b0;
              lock_err_q <= 1'b0;
            end
            CMD_PROG:  if (!susp_q) seq_q <= SQ_PROG;
            CMD_ERASE: if (!susp_q) seq_q <= SQ_ERASE;
            CMD_CONFIRM: if (ev_resume) begin
              susp_q <= 1'b0;
              mode_q <= RM_STATUS;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (busy || mode_q == RM_STATUS) rdata <= {8'h00, status_byte};
      else if (mode_q == RM_IDENT)     rdata <= {8'h00, addr[0] ? DEV_CODE : MFR_CODE};
      else                             rdata <= f_width_view(cell_val, word_sel);
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] wdata,
  input logic        busy,
  input logic [15:0] rdata,
  input rmode_e      mode_q,
  input seq_e        seq_q,
  input op_e         op_q,
  input logic        op_done,
  input logic [7:0]  status_byte
);
  AST_RESET_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_q == RM_ARRAY) && !busy); // R1

  AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rdata[15:8] == 8'h00) && !rdata[7]); // R8

  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wdata[7:0] != 8'hB0) |=> $stable(mode_q) && $stable(seq_q)); // R8

  AST_DONE_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy && status_byte[7] && (mode_q == RM_STATUS)); // R9

  AST_SUSPEND_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wdata[7:0] == 8'hB0 && op_q == OP_ERASE && !op_done)
      |=> !busy && status_byte[6] && status_byte[7]); // R7

  AST_SEQ_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SQ_ERASE && wr_en && !busy && wdata[7:0] != 8'hD0)
      |=> status_byte[5] && !busy); // R6
endmodule

bind flash_cmd_ctrl flash_cmd_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .wdata       (wdata),
  .busy        (busy),
  .rdata       (rdata),
  .mode_q      (mode_q),
  .seq_q       (seq_q),
  .op_q        (op_q),
  .op_done     (op_done),
  .status_byte (status_byte)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int PL = 8;
  localparam int EL = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, word_sel = 1'b1, boot_unlock = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy;

  int total = 0, bad = 0;
  logic [15:0] mdl [16];

  always #2 clk = ~clk;

  flash_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .word_sel(word_sel), .boot_unlock(boot_unlock),
    .rdata(rdata), .busy(busy)
  );

  function automatic logic [19:0] mk(input int b, input int w);
    return {6'd0, 2'(b), 10'($urandom), 2'(w)};
  endfunction
  function automatic int b_idx(input logic [19:0] a);
    return int'({a[13:12], a[1:0]});
  endfunction
  function automatic logic [15:0] b_view(input logic [15:0] v, input logic ws);
    return ws ? v : {8'h00, v[7:0]};
  endfunction
  function automatic logic [15:0] b_prog(input logic [15:0] o, input logic [15:0] d, input logic ws);
    return ws ? (o & d) : (o & {8'hFF, d[7:0]});
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [19:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask
  task automatic pulse_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask
  task automatic prog(input logic [19:0] a, input logic [15:0] d, output int n);
    wr(a, 16'h0040);
    wr(a, d);
    wait_idle(n);
  endtask
  task automatic erase(input int b, output int n);
    wr(mk(b, 0), 16'h0020);
    wr(mk(b, 1), 16'h00D0);
    wait_idle(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, pre, post;
    logic [19:0] a;
    void'($urandom(32'd9127));
    repeat (4) @(negedge clk);
    check("R1 busy at reset", 16'(busy), 16'h0);
    check("R1 rdata at reset", rdata, 16'h0);
    rst_n = 1'b1;

    for (int b = 0; b < 4; b++) begin
      erase(b, n);
      if (b == 0) check("R6 erase busy length", 16'(n), 16'(EL));
      for (int w = 0; w < 4; w++) mdl[b*4+w] = 16'hFFFF;
    end
    rd(mk(1, 0), v); check("R9 status after erase", v, 16'h0080);
    pulse_reset();
    rd(mk(2, 3), v); check("R1 array view after reset", v, 16'hFFFF);

    // word program with alternate setup
    a = mk(1, 2);
    wr(a, 16'h0010); wr(a, 16'h1234); wait_idle(n);
    mdl[b_idx(a)] = 16'h1234;
    check("R5 program busy length", 16'(n), 16'(PL));
    rd(a, v); check("R9 stays status", v, 16'h0080);
    rd(a, v); check("R9 stays status again", v, 16'h0080);
    wr(a, 16'h00FF);
    rd(a, v); check("R5 programmed word", v, 16'h1234);
    rd(a, v); check("R2 array persists", v, 16'h1234);
    wr(a, 16'h0000); wr(a, 16'h0034);
    rd(a, v); check("R2 non-command ignored", v, 16'h1234);

    wr(a, 16'h0090);
    rd(20'h00000, v); check("R3 manufacturer code", v, 16'h00A7);
    rd(20'h00001, v); check("R3 device code", v, 16'h00C3);
    rd(20'h00000, v); check("R3 view holds", v, 16'h00A7);

    // byte mode
    word_sel = 1'b0;
    a = mk(2, 0);
    prog(a, 16'hC35A, n); mdl[b_idx(a)] = b_prog(mdl[b_idx(a)], 16'hC35A, 1'b0);
    wr(a, 16'h00FF);
    rd(a, v); check("R5 byte read", v, 16'h005A);
    word_sel = 1'b1;
    rd(a, v); check("R5 byte program upper kept", v, 16'hFF5A);

    // null writes
    a = mk(3, 2);
    wr(a, 16'h0040); wr(a, 16'hFFFF);
    check("R10 null word no busy", 16'(busy), 16'h0);
    rd(a, v); check("R10 null word unchanged, array view", v, 16'hFFFF);
    word_sel = 1'b0;
    wr(a, 16'h0040); wr(a, 16'h00FF);
    check("R10 null byte no busy", 16'(busy), 16'h0);
    rd(a, v); check("R10 null byte unchanged", v, 16'h00FF);
    word_sel = 1'b1;
    prog(a, 16'h00FF, n); mdl[b_idx(a)] = 16'h00FF;
    check("R10 word 00FF is a program", 16'(n), 16'(PL));
    wr(a, 16'h00FF); rd(a, v); check("R10 word 00FF stored", v, 16'h00FF);

    // erase sequence error, clear
    wr(a, 16'h0020); wr(a, 16'h0055);
    check("R6 bad confirm no busy", 16'(busy), 16'h0);
    rd(a, v); check("R6 sequence error bit", v, 16'h00A0);
    rd(a, v); check("R4 status view persists", v, 16'h00A0);
    wr(a, 16'h0050);
    rd(a, v); check("R4 clear status", v, 16'h0080);
    wr(a, 16'h00FF); wr(a, 16'h0070);
    rd(a, v); check("R4 status command", v, 16'h0080);

    // commands while busy
    a = mk(1, 0);
    wr(a, 16'h0040); wr(a, 16'hF0F0); mdl[b_idx(a)] = 16'hF0F0;
    wr(a, 16'h0090);
    wr(a, 16'h00FF);
    rd(mk(0, 1), v); check("R8 busy read is status", v, 16'h0000);
    wait_idle(n);
    rd(mk(0, 1), v); check("R8 commands ignored while busy", v, 16'h0080);

    // boot block lock
    boot_unlock = 1'b0;
    a = mk(0, 3);
    wr(a, 16'h0040); wr(a, 16'h0000);
    check("R11 locked program no busy", 16'(busy), 16'h0);
    rd(a, v); check("R11 lock error bit", v, 16'h0082);
    wr(a, 16'h00FF); rd(a, v); check("R11 locked cell unchanged", v, 16'hFFFF);
    wr(a, 16'h0050);
    erase(0, n);
    rd(a, v); check("R11 locked erase", v, 16'h0082);
    wr(a, 16'h0050);
    boot_unlock = 1'b1;
    prog(a, 16'h0A0A, n); mdl[b_idx(a)] = 16'h0A0A;
    wr(a, 16'h00FF); rd(a, v); check("R11 unlocked program", v, 16'h0A0A);

    // suspend / resume
    a = mk(3, 1);
    prog(a, 16'hABCD, n); mdl[b_idx(a)] = 16'hABCD;
    wr(mk(3, 0), 16'h0020); wr(mk(3, 0), 16'h00D0);
    pre = 0;
    repeat (5) begin if (busy) pre++; @(negedge clk); end
    if (busy) pre++;
    wr(a, 16'h00B0);
    check("R7 suspend drops busy", 16'(busy), 16'h0);
    rd(a, v); check("R7 suspended status", v, 16'h00C0);
    wr(a, 16'h00FF);
    rd(a, v); check("R7 pre-erase data", v, 16'hABCD);
    wr(a, 16'h0040); wr(a, 16'h0000);
    rd(a, v); check("R7 program ignored while suspended", v, 16'hABCD);
    wr(a, 16'h00D0);
    wait_idle(post);
    check("R7 total erase cycles", 16'(pre + post), 16'(EL));
    rd(a, v); check("R7 status after resume", v, 16'h0080);
    wr(a, 16'h00FF); rd(a, v); check("R7 erased after resume", v, 16'hFFFF);
    for (int w = 0; w < 4; w++) mdl[12+w] = 16'hFFFF;

    // reset abort
    a = mk(1, 3);
    wr(a, 16'h0040); wr(a, 16'h0F0F);
    repeat (3) @(negedge clk);
    pulse_reset(); mdl[b_idx(a)] = 16'h0000;
    check("R12 not busy after abort", 16'(busy), 16'h0);
    rd(a, v); check("R12 aborted program corrupt", v, 16'h0000);
    wr(mk(2, 0), 16'h0020); wr(mk(2, 0), 16'h00D0);
    repeat (2) @(negedge clk);
    wr(a, 16'h00B0);
    pulse_reset();
    for (int w = 0; w < 4; w++) begin
      mdl[8+w] = 16'h0000;
      rd(mk(2, w), v); check("R12 aborted erase corrupt", v, 16'h0000);
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      int b, w, k;
      logic [15:0] d;
      logic ws;
      b = int'($urandom_range(0, 3)); w = int'($urandom_range(0, 3));
      k = int'($urandom_range(0, 9));
      ws = 1'($urandom); d = 16'($urandom);
      word_sel = ws;
      a = mk(b, w);
      if (k == 0) begin
        erase(b, n);
        for (int j = 0; j < 4; j++) mdl[b*4+j] = 16'hFFFF;
      end else if (k == 1) begin
        wr(a, 16'h0090);
        rd(a, v); check("R3 random identifier", v, a[0] ? 16'h00C3 : 16'h00A7);
      end else begin
        if ((ws && d == 16'hFFFF) || (!ws && d[7:0] == 8'hFF)) d[0] = 1'b0;
        prog(a, d, n);
        mdl[b_idx(a)] = b_prog(mdl[b_idx(a)], d, ws);
        check("R5 random program busy", 16'(n), 16'(PL));
      end
      wr(a, 16'h00FF);
      a = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      rd(a, v); check("R5 random array read", v, b_view(mdl[b_idx(a)], ws));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule